// File: doc/BRIEF.md
# I2C Clock-Low Timeout Guard

This block sits beside an I2C master and watches for a target that stretches the clock for too long. Software programs an 8-bit limit. On every START the guard loads a 12-bit down-counter with that limit shifted left by four bits, so the low nibble is zero. The counter then steps down once for each falling edge of the master's own internal bit clock, which keeps running at the configured bus rate even while SCL is held low from outside. Whenever SCL is seen high, the count is reloaded and the low period is measured again from the start.

When the count reaches zero the guard sets three outputs. It raises a sticky raw interrupt and a timeout status flag. It also asks the master state machine to abort with a STOP, and it holds that request until both bus lines are released. The status flag clears only on a sent STOP or on a master reset. The interrupt clears only on a write-one-to-clear strobe or on a reset. Both bus lines pass through a synchroniser, and the synchronised levels are presented as a bus monitor that software can read.

Top module: `i2c_scl_lowtime_guard`

## Requirements
- R1: After reset, `irq_raw`, `clkto_stat` and `abort_req` are 0, and `mon_scl` and `mon_sda` read 1 while the bus lines are high.
- R2: `mon_scl` and `mon_sda` follow `scl_raw` and `sda_raw` through a two-flop synchroniser. A change on a line is visible after the second rising clock edge and not after the first.
- R3: A START loads the count with `{limit, 4'b0000}`. With `limit` = 0xDA and SCL held low, 3487 ticks leave every flag clear, and the 3488th tick raises `irq_raw` and `clkto_stat`.
- R4: A `limit` of 0x00 or 0x01 acts as 0x02, which gives 32 ticks to the timeout.
- R5: Whenever the synchronised SCL is high, the count is reloaded from `limit`. Ticks taken before a release do not count toward the next low period.
- R6: The counter counts only between a START and the next STOP. Ticks with SCL low and no START since the last STOP never cause a timeout.
- R7: `irq_raw` stays set until `irq_clr` is pulsed or a reset occurs. A STOP does not clear it. If a timeout and `irq_clr` occur in the same cycle, the flag stays set.
- R8: `abort_req` is 1 only while a timeout is pending and both synchronised lines read high. It drops in the cycle after `stop_sent`.
- R9: `clkto_stat` clears on `stop_sent` or `mst_rst`. `mst_rst` also clears `irq_raw` and `abort_req`.
- R10: A timeout fires only once per load. The count holds at zero and does not wrap, so further ticks after an `irq_clr` do not set `irq_raw` again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mst_rst | input | 1 | Synchronous master reset, active high |
| limit | input | 8 | Programmed timeout, upper bits of the count |
| scl_raw | input | 1 | Raw SCL line level |
| sda_raw | input | 1 | Raw SDA line level |
| start_det | input | 1 | Single-cycle strobe: START detected |
| stop_sent | input | 1 | Single-cycle strobe: STOP sent |
| bit_tick | input | 1 | Single-cycle strobe: falling edge of the master's internal bit clock |
| irq_clr | input | 1 | Write-one-to-clear strobe for `irq_raw` |
| irq_raw | output | 1 | Sticky raw clock-timeout interrupt |
| clkto_stat | output | 1 | Clock-timeout status |
| abort_req | output | 1 | Request to abort with a STOP |
| mon_scl | output | 1 | Synchronised SCL level |
| mon_sda | output | 1 | Synchronised SDA level |

## Verification
The monitor outputs settle two rising edges after a line changes. Every reload or count decision depends on SCL only through that synchroniser, so the bench waits three edges after moving SCL before it issues START or ticks. `irq_raw` and `clkto_stat` rise on the same edge that takes the final tick. `abort_req` rises two edges after the last bus line is released and falls one edge after `stop_sent`. The bench drives stimulus on falling clock edges and samples exactly one edge later, or one edge earlier where the check expects the old value. Random limits and random release points are mixed with directed cases. Expected tick counts come from a bench function that applies the clamp and the four-bit shift.

// File: rtl/sclg_pkg.sv
package sclg_pkg;
    localparam int LIM_W_DEF     = 8;
    localparam int FRAC_W_DEF    = 4;
    localparam int MIN_LIM_DEF   = 2;
    localparam int SYNC_DEPTH_DEF = 2;
endpackage

// File: rtl/sclg_sync.sv
module sclg_sync #(
    parameter int W      = 2,
    parameter int STAGES = sclg_pkg::SYNC_DEPTH_DEF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [STAGES-1:0][W-1:0] chain;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain[0] = din;
        for (int s = 1; s < STAGES; s++) begin
            st_d.chain[s] = st_q.chain[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '1;    // idle bus lines read high
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = st_q.chain[STAGES-1];
endmodule

// File: rtl/sclg_counter.sv
module sclg_counter #(
    parameter int LIM_W   = sclg_pkg::LIM_W_DEF,
    parameter int FRAC_W  = sclg_pkg::FRAC_W_DEF,
    parameter int MIN_LIM = sclg_pkg::MIN_LIM_DEF,
    localparam int CNT_W  = LIM_W + FRAC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mst_rst,
    input  logic             start_det,
    input  logic             stop_sent,
    input  logic             scl_high,
    input  logic             bit_tick,
    input  logic [LIM_W-1:0] limit,
    output logic             fire,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [LIM_W-1:0] MIN_V = LIM_W'(MIN_LIM);
    localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

    typedef struct packed {
        logic             armed;
        logic             done;
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic [LIM_W-1:0] lim_eff;
    logic [CNT_W-1:0] load_v;

    always_comb begin
        lim_eff = (limit < MIN_V) ? MIN_V : limit;
        load_v  = {lim_eff, {FRAC_W{1'b0}}};
    end

    always_comb begin
        st_d = st_q;
        fire = 1'b0;
        if (mst_rst || stop_sent) begin
            st_d.armed = 1'b0;
            st_d.done  = 1'b0;
        end else if (start_det) begin
            st_d.armed = 1'b1;
            st_d.done  = 1'b0;
            st_d.cnt   = load_v;
        end else if (st_q.armed && !st_q.done) begin
            if (scl_high) begin
                st_d.cnt = load_v;
            end else if (bit_tick) begin
                st_d.cnt = st_q.cnt - ONE_C;
                if (st_q.cnt == ONE_C) begin
                    st_d.done = 1'b1;
                    fire      = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt = st_q.cnt;
endmodule

// File: rtl/sclg_flags.sv
module sclg_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic mst_rst,
    input  logic stop_sent,
    input  logic irq_clr,
    input  logic fire,
    input  logic scl_high,
    input  logic sda_high,
    output logic irq_raw,
    output logic clkto_stat,
    output logic abort_req
);
    typedef struct packed {
        logic irq;
        logic stat;
        logic pend;
    } flag_st_t;

    flag_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (mst_rst) begin
            st_d = '0;
        end else begin
            if (irq_clr) st_d.irq = 1'b0;
            if (stop_sent) begin
                st_d.stat = 1'b0;
                st_d.pend = 1'b0;
            end
            if (fire) begin
                st_d.irq  = 1'b1;
                st_d.stat = 1'b1;
                st_d.pend = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_raw    = st_q.irq;
    assign clkto_stat = st_q.stat;
    assign abort_req  = st_q.pend & scl_high & sda_high;
endmodule

// File: rtl/i2c_scl_lowtime_guard.sv
module i2c_scl_lowtime_guard #(
    parameter int LIM_W      = sclg_pkg::LIM_W_DEF,
    parameter int FRAC_W     = sclg_pkg::FRAC_W_DEF,
    parameter int MIN_LIM    = sclg_pkg::MIN_LIM_DEF,
    parameter int SYNC_DEPTH = sclg_pkg::SYNC_DEPTH_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mst_rst,
    input  logic [LIM_W-1:0] limit,
    input  logic             scl_raw,
    input  logic             sda_raw,
    input  logic             start_det,
    input  logic             stop_sent,
    input  logic             bit_tick,
    input  logic             irq_clr,
    output logic             irq_raw,
    output logic             clkto_stat,
    output logic             abort_req,
    output logic             mon_scl,
    output logic             mon_sda
);
    localparam int CNT_W = LIM_W + FRAC_W;

    logic [1:0]       lines_s;
    logic             fire_w;
    logic [CNT_W-1:0] cnt_w;

    sclg_sync #(.W(2), .STAGES(SYNC_DEPTH)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({sda_raw, scl_raw}),
        .dout (lines_s)
    );

    sclg_counter #(.LIM_W(LIM_W), .FRAC_W(FRAC_W), .MIN_LIM(MIN_LIM)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .mst_rst  (mst_rst),
        .start_det(start_det),
        .stop_sent(stop_sent),
        .scl_high (lines_s[0]),
        .bit_tick (bit_tick),
        .limit    (limit),
        .fire     (fire_w),
        .cnt      (cnt_w)
    );

    sclg_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .mst_rst   (mst_rst),
        .stop_sent (stop_sent),
        .irq_clr   (irq_clr),
        .fire      (fire_w),
        .scl_high  (lines_s[0]),
        .sda_high  (lines_s[1]),
        .irq_raw   (irq_raw),
        .clkto_stat(clkto_stat),
        .abort_req (abort_req)
    );

    assign mon_scl = lines_s[0];
    assign mon_sda = lines_s[1];
endmodule

// File: rtl/sclg_checker.sv
module sclg_checker #(
    parameter int CNT_W = 12,
    parameter int FLOOR = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mst_rst,
    input logic             start_det,
    input logic             stop_sent,
    input logic             irq_clr,
    input logic             irq_raw,
    input logic             clkto_stat,
    input logic             abort_req,
    input logic             mon_scl,
    input logic             mon_sda,
    input logic [CNT_W-1:0] cnt_mon
);
    p_irq_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_raw && !irq_clr && !mst_rst) |=> irq_raw);

    p_stop_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_sent || mst_rst) |=> !clkto_stat);

    p_mrst_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mst_rst |=> (!irq_raw && !abort_req));

    p_abort_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        abort_req |-> (mon_scl && mon_sda && clkto_stat));

    p_stat_with_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clkto_stat) |-> irq_raw);

    p_no_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_mon == '0 && !start_det && !mst_rst) |=> cnt_mon == '0);

    p_load_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && !stop_sent && !mst_rst) |=> cnt_mon >= CNT_W'(FLOOR));
endmodule

bind i2c_scl_lowtime_guard sclg_checker #(
    .CNT_W(CNT_W),
    .FLOOR(MIN_LIM * (1 << FRAC_W))
) u_sclg_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mst_rst   (mst_rst),
    .start_det (start_det),
    .stop_sent (stop_sent),
    .irq_clr   (irq_clr),
    .irq_raw   (irq_raw),
    .clkto_stat(clkto_stat),
    .abort_req (abort_req),
    .mon_scl   (mon_scl),
    .mon_sda   (mon_sda),
    .cnt_mon   (cnt_w)
);

// File: tb/i2c_scl_lowtime_guard_tb_top.sv
`timescale 1ns/1ps
module i2c_scl_lowtime_guard_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mst_rst = 1'b0;
    logic [7:0] limit = 8'h02;
    logic scl_raw = 1'b1;
    logic sda_raw = 1'b1;
    logic start_det = 1'b0;
    logic stop_sent = 1'b0;
    logic bit_tick = 1'b0;
    logic irq_clr = 1'b0;
    logic irq_raw, clkto_stat, abort_req, mon_scl, mon_sda;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    i2c_scl_lowtime_guard dut_i (
        .clk(clk), .rst_n(rst_n), .mst_rst(mst_rst), .limit(limit),
        .scl_raw(scl_raw), .sda_raw(sda_raw), .start_det(start_det),
        .stop_sent(stop_sent), .bit_tick(bit_tick), .irq_clr(irq_clr),
        .irq_raw(irq_raw), .clkto_stat(clkto_stat), .abort_req(abort_req),
        .mon_scl(mon_scl), .mon_sda(mon_sda)
    );

    function automatic int eff_ticks(input logic [7:0] lim);
        return ((lim < 8'h02) ? 2 : int'(lim)) * 16;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_start();
        start_det = 1'b1; cyc(1); start_det = 1'b0;
    endtask

    task automatic pulse_stop();
        stop_sent = 1'b1; cyc(1); stop_sent = 1'b0;
    endtask

    task automatic pulse_clr();
        irq_clr = 1'b1; cyc(1); irq_clr = 1'b0;
    endtask

    task automatic ticks(input int n);
        if (n > 0) begin
            bit_tick = 1'b1; cyc(n); bit_tick = 1'b0;
        end
    endtask

    task automatic scl_set(input logic v);
        scl_raw = v; cyc(3);
    endtask

    // one session: START with SCL low, optional release after 'part' ticks,
    // then a full low period that must time out exactly on its last tick
    task automatic session(input logic [7:0] lim, input int part, input string req);
        int n;
        n = eff_ticks(lim);
        limit = lim;
        scl_set(1'b0);
        pulse_start();
        if (part > 0) begin
            ticks(part);
            chk(irq_raw == 1'b0, req, irq_raw, 0);
            scl_set(1'b1);
            scl_set(1'b0);
        end
        ticks(n - 1);
        chk(irq_raw == 1'b0 && clkto_stat == 1'b0, req, irq_raw, 0);
        ticks(1);
        chk(irq_raw == 1'b1 && clkto_stat == 1'b1, req, irq_raw, 1);
        scl_set(1'b1);
        pulse_stop();
        pulse_clr();
    endtask

    initial begin
        void'($urandom(32'h5C1A_0077));
        cyc(3);
        // R1: reset state
        chk(irq_raw == 0 && clkto_stat == 0 && abort_req == 0, "R1", irq_raw, 0);
        chk(mon_scl == 1 && mon_sda == 1, "R1", mon_scl, 1);
        rst_n = 1'b1;
        cyc(2);

        // R2: two-flop latency on the monitor
        sda_raw = 1'b0;
        cyc(1);
        chk(mon_sda == 1'b1, "R2", mon_sda, 1);
        cyc(1);
        chk(mon_sda == 1'b0, "R2", mon_sda, 0);
        sda_raw = 1'b1;
        scl_raw = 1'b0;
        cyc(2);
        chk(mon_scl == 1'b0 && mon_sda == 1'b1, "R2", mon_scl, 0);
        scl_raw = 1'b1;
        cyc(2);

        // R3: 0xDA gives 3488 ticks
        chk(eff_ticks(8'hDA) == 3488, "R3", eff_ticks(8'hDA), 3488);
        session(8'hDA, 0, "R3");

        // R4: clamp of 0x00 and 0x01
        session(8'h00, 0, "R4");
        session(8'h01, 0, "R4");

        // R5: reload on release
        session(8'h03, 40, "R5");

        // R6: no counting without START
        limit = 8'h02;
        scl_set(1'b0);
        ticks(100);
        chk(irq_raw == 0 && clkto_stat == 0, "R6", irq_raw, 0);
        pulse_start();
        pulse_stop();
        ticks(100);
        chk(irq_raw == 0 && clkto_stat == 0, "R6", irq_raw, 0);

        // R8, R7, R10: timeout with SDA low, abort waits for both lines
        sda_raw = 1'b0;
        pulse_start();
        ticks(31);
        irq_clr = 1'b1;        // R7: set wins over clear
        ticks(1);
        irq_clr = 1'b0;
        chk(irq_raw == 1 && clkto_stat == 1, "R7", irq_raw, 1);
        chk(abort_req == 0, "R8", abort_req, 0);
        pulse_clr();
        ticks(40);
        chk(irq_raw == 0 && clkto_stat == 1, "R10", irq_raw, 0);
        scl_set(1'b1);
        chk(abort_req == 0, "R8", abort_req, 0);
        sda_raw = 1'b1;
        cyc(1);
        chk(abort_req == 0, "R8", abort_req, 0);
        cyc(1);
        chk(abort_req == 1, "R8", abort_req, 1);
        pulse_stop();
        chk(abort_req == 0 && clkto_stat == 0, "R8", abort_req, 0);

        // R7: STOP leaves the interrupt set
        scl_set(1'b0);
        pulse_start();
        ticks(32);
        scl_set(1'b1);
        pulse_stop();
        chk(irq_raw == 1 && clkto_stat == 0, "R7", irq_raw, 1);
        pulse_clr();
        chk(irq_raw == 0, "R7", irq_raw, 0);

        // R9: master reset clears everything
        scl_set(1'b0);
        pulse_start();
        ticks(32);
        scl_set(1'b1);
        chk(abort_req == 1, "R9", abort_req, 1);
        mst_rst = 1'b1; cyc(1); mst_rst = 1'b0;
        chk(irq_raw == 0 && clkto_stat == 0 && abort_req == 0, "R9", clkto_stat, 0);

        // random sessions: R3 and R5
        for (int t = 0; t < 8; t++) begin
            logic [7:0] lim;
            int part;
            lim = 8'($urandom_range(0, 7));
            part = ($urandom_range(0, 1) == 1) ? int'($urandom_range(1, eff_ticks(lim) - 1)) : 0;
            session(lim, part, (part > 0) ? "R5" : "R3");
        end

        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule